// File: doc/BRIEF.md
# Translation Table Maintenance Engine

This block runs maintenance commands against a small set of I/O translation tables. Each table has a 32-bit identifier, a bus offset, a page shift and an entry count, all fixed by parameters. A command names a table, an I/O address and an operand. There are four operations: store one entry, read one entry back, fill a run of consecutive pages with one value, and write a run of pages with values fetched from a list in memory. Every command ends with a one-cycle response that carries a success or parameter-error status.

Each time an entry is written, the block emits a one-cycle invalidation notice, so downstream translation caches can drop stale pages. For list-driven writes, a minimal read master fetches one 64-bit list word per page. The engine takes one command at a time.

Top module: `tte_maint_engine`

## Requirements
- R1: A command whose table ID has any of bits 63:32 set gets a parameter error (resp_status = 1), and no entry is written and no notice is emitted.
- R2: A command whose ID bits 31:0 match no configured table gets a parameter error, with no write and no notice.
- R3: The I/O address is aligned down to the table's page size. The entry index is (aligned address − bus offset) >> page shift, as unsigned 64-bit arithmetic. An index at or beyond the entry count gives a parameter error and writes nothing.
- R4: Operation code 0 (store) writes cmd_data into the indexed entry and responds with success (resp_status = 0).
- R5: Operation code 1 (read) returns the stored 64-bit entry on resp_data only on success. On an error, resp_data is zero.
- R6: Operation code 2 (fill) is rejected up front, with nothing written, when cmd_count is zero or exceeds the table's entry count. Otherwise it writes cmd_data to cmd_count consecutive pages, advancing one page size each time.
- R7: Operation code 3 (list write) is rejected up front, with no fetch and no write, when cmd_count is zero, when cmd_count exceeds 512, or when the list address in cmd_data has any of bits 11:0 set.
- R8: A list write fetches 8-byte words from cmd_data + 8·i for page i. A fetch holds mem_req until mem_rvalid. Byte lane k of mem_rdata (bits 8k+7:8k) is the byte at address + k, and the word is big-endian, so the byte at offset 0 is the most significant byte. Each word goes to the next page.
- R9: A fill or list write stops at the first page whose index is out of range and reports a parameter error. Entries already written in that run keep their new values.
- R10: Every entry write produces one notice, in the cycle after the write, with these fields:
  - note_iova: the page-aligned I/O address.
  - note_xlat: the written value ANDed with the page mask.
  - note_mask: the inverse page mask.
  - note_perm: bits 1:0 of the value (0 none, 1 read, 2 write, 3 read/write).
- R11: A command is accepted when cmd_valid is high while busy is low. From the next cycle, busy stays high through the single cycle in which resp_valid is high. Any cmd_valid seen while busy is high is ignored.
- R12: Reset clears every entry of every table to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 store, 1 read, 2 fill, 3 list write |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | I/O address of the first page |
| cmd_data | input | 64 | Entry value (store, fill) or list address (list write) |
| cmd_count | input | 64 | Page count for fill and list write |
| busy | output | 1 | A command is in progress |
| resp_valid | output | 1 | Final status is valid this cycle |
| resp_status | output | 1 | 0 success, 1 parameter error |
| resp_data | output | 64 | Entry returned by a successful read |
| note_valid | output | 1 | Invalidation notice strobe |
| note_iova | output | 64 | Page-aligned I/O address |
| note_xlat | output | 64 | Translated page address |
| note_mask | output | 64 | Offset mask within the page |
| note_perm | output | 2 | Decoded permission |
| mem_req | output | 1 | List word fetch request |
| mem_addr | output | 64 | List word address |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 64 | Fetched bytes, lane k = address + k |

## Verification
The bench builds the block with its default parameters. These give two tables that differ in every attribute: one at offset zero with 4 KiB pages and 8 entries, and one at offset 4 GiB with 64 KiB pages and 16 entries. A single bench therefore shows that the page mask, the offset subtraction and the wrap of an address below the offset all follow the selected table. The shallow tables put the end of a table within a few pages. That lets fill and list runs overrun it, and lets a list run with the maximum page count of 512 stop after two writes instead of hundreds.

// File: rtl/tte_pkg.sv
package tte_pkg;
   typedef enum logic [1:0] {
      OP_STORE = 2'd0,
      OP_READ  = 2'd1,
      OP_FILL  = 2'd2,
      OP_LIST  = 2'd3
   } tte_op_e;

   typedef enum logic {
      STAT_OK    = 1'b0,
      STAT_PARAM = 1'b1
   } tte_status_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_FETCH,
      S_STEP,
      S_RESP
   } tte_state_e;
endpackage

// File: rtl/tte_table_select.sv
module tte_table_select #(
   parameter int N_TABLES = 2,
   parameter int SEL_W    = 1,
   parameter logic [N_TABLES-1:0][31:0] TBL_ID     = '0,
   parameter logic [N_TABLES-1:0][63:0] TBL_OFFSET = '0,
   parameter logic [N_TABLES-1:0][5:0]  TBL_SHIFT  = '0,
   parameter logic [N_TABLES-1:0][31:0] TBL_COUNT  = '0
) (
   input  logic [63:0]      id,
   output logic             hit,
   output logic [SEL_W-1:0] sel,
   output logic [63:0]      offset,
   output logic [5:0]       shift,
   output logic [31:0]      count
);
   logic [N_TABLES-1:0] match;

   for (genvar t = 0; t < N_TABLES; t++) begin : g_match
      assign match[t] = (id[31:0] == TBL_ID[t]);
   end

   always_comb begin
      sel    = '0;
      offset = '0;
      shift  = '0;
      count  = '0;
      for (int t = N_TABLES - 1; t >= 0; t--) begin
         if (match[t]) begin
            sel    = t[SEL_W-1:0];
            offset = TBL_OFFSET[t];
            shift  = TBL_SHIFT[t];
            count  = TBL_COUNT[t];
         end
      end
   end

   assign hit = (id[63:32] == 32'd0) && (|match);
endmodule

// File: rtl/tte_entry_store.sv
module tte_entry_store #(
   parameter int N_TABLES = 2,
   parameter int SEL_W    = 1,
   parameter int IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] sel,
   input  logic [IDX_W-1:0] idx,
   input  logic [63:0]      wr_data,
   output logic [63:0]      rd_data
);
   localparam int SLOTS = 1 << IDX_W;

   logic [N_TABLES-1:0][63:0] bank_rd;

   for (genvar t = 0; t < N_TABLES; t++) begin : g_bank
      logic [63:0] slot [SLOTS];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
         end else if (wr_en && (sel == t[SEL_W-1:0])) begin
            slot[idx] <= wr_data;
         end
      end
      assign bank_rd[t] = slot[idx];
   end

   always_comb begin
      rd_data = '0;
      for (int t = 0; t < N_TABLES; t++) begin
         if (sel == t[SEL_W-1:0]) rd_data = bank_rd[t];
      end
   end
endmodule

// File: rtl/tte_list_fetch.sv
module tte_list_fetch (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [63:0] start_addr,
   output logic        mem_req,
   output logic [63:0] mem_addr,
   input  logic        mem_rvalid,
   input  logic [63:0] mem_rdata,
   output logic        word_valid,
   output logic [63:0] word
);
   logic [63:0] swapped;

   for (genvar k = 0; k < 8; k++) begin : g_swap
      assign swapped[8*(7-k) +: 8] = mem_rdata[8*k +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         word_valid <= 1'b0;
         word       <= '0;
      end else begin
         word_valid <= 1'b0;
         if (start) begin
            mem_req  <= 1'b1;
            mem_addr <= start_addr;
         end else if (mem_req && mem_rvalid) begin
            mem_req    <= 1'b0;
            word       <= swapped;
            word_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tte_maint_engine.sv
module tte_maint_engine
   import tte_pkg::*;
#(
   parameter int N_TABLES    = 2,
   parameter int ENTRY_DEPTH = 16,
   parameter int LIST_MAX    = 512,
   parameter int LIST_ALIGN  = 12,
   parameter logic [N_TABLES-1:0][31:0] TBL_ID     = {32'h0000_0020, 32'h0000_0010},
   parameter logic [N_TABLES-1:0][63:0] TBL_OFFSET = {64'h0000_0001_0000_0000, 64'h0},
   parameter logic [N_TABLES-1:0][5:0]  TBL_SHIFT  = {6'd16, 6'd12},
   parameter logic [N_TABLES-1:0][31:0] TBL_COUNT  = {32'd16, 32'd8}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_op,
   input  logic [63:0] cmd_id,
   input  logic [63:0] cmd_addr,
   input  logic [63:0] cmd_data,
   input  logic [63:0] cmd_count,
   output logic        busy,
   output logic        resp_valid,
   output logic        resp_status,
   output logic [63:0] resp_data,
   output logic        note_valid,
   output logic [63:0] note_iova,
   output logic [63:0] note_xlat,
   output logic [63:0] note_mask,
   output logic [1:0]  note_perm,
   output logic        mem_req,
   output logic [63:0] mem_addr,
   input  logic        mem_rvalid,
   input  logic [63:0] mem_rdata
);
   localparam int SEL_W    = (N_TABLES > 1) ? $clog2(N_TABLES) : 1;
   localparam int IDX_W    = $clog2(ENTRY_DEPTH);
   localparam int LOOP_MAX = (LIST_MAX > ENTRY_DEPTH) ? LIST_MAX : ENTRY_DEPTH;
   localparam int LOOP_W   = $clog2(LOOP_MAX + 1);

   if (ENTRY_DEPTH < 2) begin : g_bad_depth
      $error("ENTRY_DEPTH must be at least 2");
   end
   if (LIST_ALIGN < 3 || LIST_ALIGN > 63) begin : g_bad_align
      $error("LIST_ALIGN out of range");
   end
   for (genvar t = 0; t < N_TABLES; t++) begin : g_cfg_chk
      if (TBL_COUNT[t] == 0 || TBL_COUNT[t] > ENTRY_DEPTH) begin : g_bad_count
         $error("table entry count out of range");
      end
   end

   tte_state_e  state_q;
   tte_op_e     op_q;
   logic [63:0] id_q, addr_q, data_q, count_q, list_ptr_q;
   logic [LOOP_W-1:0] left_q;
   logic        status_q;

   logic             hit;
   logic [SEL_W-1:0] sel;
   logic [63:0]      t_offset;
   logic [5:0]       t_shift;
   logic [31:0]      t_count;

   tte_table_select #(
      .N_TABLES(N_TABLES), .SEL_W(SEL_W), .TBL_ID(TBL_ID),
      .TBL_OFFSET(TBL_OFFSET), .TBL_SHIFT(TBL_SHIFT), .TBL_COUNT(TBL_COUNT)
   ) u_select (
      .id(id_q), .hit(hit), .sel(sel), .offset(t_offset),
      .shift(t_shift), .count(t_count)
   );

   logic [63:0] page_mask, page_size, aligned, index64, wr_value, rd_data;
   logic        in_range, wr_en, fetch_start, word_valid;
   logic [63:0] fetch_addr, word;

   assign page_mask = ~64'd0 << t_shift;
   assign page_size = 64'd1 << t_shift;
   assign aligned   = addr_q & page_mask;
   assign index64   = (aligned - t_offset) >> t_shift;
   assign in_range  = index64 < {32'd0, t_count};
   assign wr_value  = (op_q == OP_LIST) ? word : data_q;
   assign wr_en     = (state_q == S_STEP) && (op_q != OP_READ) && in_range;

   logic list_ok, fill_ok, more;
   assign list_ok = (count_q != 0) && (count_q <= 64'(LIST_MAX))
                    && (data_q[LIST_ALIGN-1:0] == '0);
   assign fill_ok = (count_q != 0) && (count_q <= {32'd0, t_count});
   assign more    = (left_q != 1);

   assign fetch_start = ((state_q == S_CHECK) && hit && (op_q == OP_LIST) && list_ok)
                     || (wr_en && (op_q == OP_LIST) && more);
   assign fetch_addr  = (state_q == S_CHECK) ? data_q : list_ptr_q;

   tte_entry_store #(.N_TABLES(N_TABLES), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
      .idx(index64[IDX_W-1:0]), .wr_data(wr_value), .rd_data(rd_data)
   );

   tte_list_fetch u_fetch (
      .clk(clk), .rst_n(rst_n), .start(fetch_start), .start_addr(fetch_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .word_valid(word_valid), .word(word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         op_q       <= OP_STORE;
         id_q       <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         count_q    <= '0;
         list_ptr_q <= '0;
         left_q     <= '0;
         status_q   <= STAT_OK;
         resp_data  <= '0;
      end else begin
         if (fetch_start) list_ptr_q <= fetch_addr + 64'd8;
         case (state_q)
            S_IDLE: if (cmd_valid) begin
               op_q      <= tte_op_e'(cmd_op);
               id_q      <= cmd_id;
               addr_q    <= cmd_addr;
               data_q    <= cmd_data;
               count_q   <= cmd_count;
               resp_data <= '0;
               state_q   <= S_CHECK;
            end
            S_CHECK: begin
               left_q <= count_q[LOOP_W-1:0];
               if (!hit) begin
                  status_q <= STAT_PARAM;
                  state_q  <= S_RESP;
               end else begin
                  case (op_q)
                     OP_STORE, OP_READ: begin
                        left_q  <= LOOP_W'(1);
                        state_q <= S_STEP;
                     end
                     OP_FILL: begin
                        status_q <= fill_ok ? STAT_OK : STAT_PARAM;
                        state_q  <= fill_ok ? S_STEP : S_RESP;
                     end
                     default: begin
                        status_q <= list_ok ? STAT_OK : STAT_PARAM;
                        state_q  <= list_ok ? S_FETCH : S_RESP;
                     end
                  endcase
               end
            end
            S_FETCH: if (word_valid) state_q <= S_STEP;
            S_STEP: begin
               if (!in_range) begin
                  status_q <= STAT_PARAM;
                  state_q  <= S_RESP;
               end else if (op_q == OP_READ) begin
                  status_q  <= STAT_OK;
                  resp_data <= rd_data;
                  state_q   <= S_RESP;
               end else if (!more) begin
                  status_q <= STAT_OK;
                  state_q  <= S_RESP;
               end else begin
                  left_q  <= left_q - 1'b1;
                  addr_q  <= aligned + page_size;
                  state_q <= (op_q == OP_LIST) ? S_FETCH : S_STEP;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         note_valid <= 1'b0;
         note_iova  <= '0;
         note_xlat  <= '0;
         note_mask  <= '0;
         note_perm  <= '0;
      end else begin
         note_valid <= wr_en;
         if (wr_en) begin
            note_iova <= aligned;
            note_xlat <= wr_value & page_mask;
            note_mask <= ~page_mask;
            note_perm <= wr_value[1:0];
         end
      end
   end

   assign busy        = (state_q != S_IDLE);
   assign resp_valid  = (state_q == S_RESP);
   assign resp_status = status_q;
endmodule

// File: rtl/tte_maint_engine_chk.sv
module tte_maint_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        busy,
   input logic        resp_valid,
   input logic        resp_status,
   input logic [63:0] resp_data,
   input logic        note_valid,
   input logic [63:0] note_iova,
   input logic [63:0] note_xlat,
   input logic [63:0] note_mask,
   input logic        mem_req
);
   AST_RESP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> busy); // R11
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R11
   AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid)); // R11
   AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status) |-> (resp_data == 64'd0)); // R5
   AST_NOTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      note_valid |-> (((note_iova & note_mask) == 64'd0) && ((note_xlat & note_mask) == 64'd0))); // R10
   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      note_valid |-> (((note_mask + 64'd1) & note_mask) == 64'd0)); // R10
   AST_NOTE_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      note_valid |-> busy); // R10
   AST_FETCH_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R8
endmodule

bind tte_maint_engine tte_maint_engine_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
   .resp_valid(resp_valid), .resp_status(resp_status), .resp_data(resp_data),
   .note_valid(note_valid), .note_iova(note_iova), .note_xlat(note_xlat),
   .note_mask(note_mask), .mem_req(mem_req)
);

// File: tb/tte_maint_engine_tb_top.sv
`timescale 1ns/1ps
module tte_maint_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [63:0] cmd_id = '0, cmd_addr = '0, cmd_data = '0, cmd_count = '0;
   logic        busy, resp_valid, resp_status;
   logic [63:0] resp_data;
   logic        note_valid;
   logic [63:0] note_iova, note_xlat, note_mask;
   logic [1:0]  note_perm;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int note_total = 0;
   logic [63:0] last_iova, last_xlat, last_mask;
   logic [1:0]  last_perm;
   logic [63:0] listmem [64];
   logic        lat = 1'b0;
   logic        got_status;
   logic [63:0] got_data;
   int          got_notes;

   always #2 clk = ~clk;

   tte_maint_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .cmd_count(cmd_count), .busy(busy), .resp_valid(resp_valid),
      .resp_status(resp_status), .resp_data(resp_data),
      .note_valid(note_valid), .note_iova(note_iova), .note_xlat(note_xlat),
      .note_mask(note_mask), .note_perm(note_perm), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [63:0] bswap(input logic [63:0] v);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*(7-k) +: 8] = v[8*k +: 8];
      return r;
   endfunction

   // memory model: answers two cycles after a request is seen
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req && !mem_rvalid && !lat) lat <= 1'b1;
      else if (lat) begin
         lat        <= 1'b0;
         mem_rvalid <= 1'b1;
         mem_rdata  <= bswap(listmem[(mem_addr >> 3) & 64'd63]);
      end
   end

   always @(negedge clk) begin
      if (note_valid) begin
         note_total <= note_total + 1;
         last_iova  <= note_iova;
         last_xlat  <= note_xlat;
         last_mask  <= note_mask;
         last_perm  <= note_perm;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [63:0] id,
                          input logic [63:0] addr, input logic [63:0] data,
                          input logic [63:0] cnt);
      int base;
      int waited;
      @(negedge clk);
      base = note_total;
      cmd_op = op; cmd_id = id; cmd_addr = addr; cmd_data = data; cmd_count = cnt;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      waited = 0;
      while (!resp_valid && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      chk(resp_valid, "R11 response timeout", {63'd0, resp_valid}, 64'd1);
      got_status = resp_status;
      got_data   = resp_data;
      @(negedge clk);
      got_notes = note_total - base;
   endtask

   task automatic expect_resp(input string req, input logic st, input int notes);
      chk(got_status == st, {req, " status"}, {63'd0, got_status}, {63'd0, st});
      chk(got_notes == notes, {req, " notice count"}, 64'(got_notes), 64'(notes));
   endtask

   task automatic expect_entry(input string req, input logic [63:0] id,
                               input logic [63:0] addr, input logic [63:0] val);
      run_cmd(2'd1, id, addr, 64'd0, 64'd0);
      chk(got_status == 1'b0, {req, " read status"}, {63'd0, got_status}, 64'd0);
      chk(got_data == val, {req, " read value"}, got_data, val);
   endtask

   task automatic t_reset;
      chk(!busy && !resp_valid && !note_valid && !mem_req, "R11 idle after reset",
          {60'd0, busy, resp_valid, note_valid, mem_req}, 64'd0);
      expect_entry("R12", 64'h10, 64'h5000, 64'd0);
   endtask

   task automatic t_store_read;
      run_cmd(2'd0, 64'h10, 64'h3123, 64'hABCD_E003, 64'd0);
      expect_resp("R4", 1'b0, 1);
      chk(last_iova == 64'h3000, "R10 iova", last_iova, 64'h3000);
      chk(last_xlat == 64'hABCD_E000, "R10 xlat", last_xlat, 64'hABCD_E000);
      chk(last_mask == 64'hFFF, "R10 mask", last_mask, 64'hFFF);
      chk(last_perm == 2'd3, "R10 perm", {62'd0, last_perm}, 64'd3);
      expect_entry("R5", 64'h10, 64'h3FFF, 64'hABCD_E003);
      run_cmd(2'd0, 64'h20, 64'h1_0002_1234, 64'h5_4321_0001, 64'd0);
      expect_resp("R3 offset table", 1'b0, 1);
      chk(last_iova == 64'h1_0002_0000, "R10 iova 64K", last_iova, 64'h1_0002_0000);
      chk(last_xlat == 64'h5_4321_0000, "R10 xlat 64K", last_xlat, 64'h5_4321_0000);
      chk(last_mask == 64'hFFFF, "R10 mask 64K", last_mask, 64'hFFFF);
      chk(last_perm == 2'd1, "R10 perm 64K", {62'd0, last_perm}, 64'd1);
      expect_entry("R3", 64'h20, 64'h1_0002_FFFF, 64'h5_4321_0001);
   endtask

   task automatic t_bad_id;
      run_cmd(2'd0, 64'h1_0000_0010, 64'h3000, 64'h1111, 64'd0);
      expect_resp("R1", 1'b1, 0);
      run_cmd(2'd1, 64'h1_0000_0010, 64'h3000, 64'd0, 64'd0);
      chk(got_status == 1'b1, "R1 read", {63'd0, got_status}, 64'd1);
      chk(got_data == 64'd0, "R5 data on error", got_data, 64'd0);
      run_cmd(2'd0, 64'h30, 64'h3000, 64'h1111, 64'd0);
      expect_resp("R2", 1'b1, 0);
      expect_entry("R1 no write", 64'h10, 64'h3000, 64'hABCD_E003);
   endtask

   task automatic t_bounds;
      run_cmd(2'd0, 64'h10, 64'h8000, 64'h2222, 64'd0);
      expect_resp("R3 index at count", 1'b1, 0);
      run_cmd(2'd0, 64'h20, 64'h1_0000, 64'h2222, 64'd0);
      expect_resp("R3 below offset", 1'b1, 0);
      run_cmd(2'd0, 64'h20, 64'h1_000F_0000, 64'h4444, 64'd0);
      expect_resp("R3 last index", 1'b0, 1);
      run_cmd(2'd1, 64'h10, 64'h8000, 64'd0, 64'd0);
      chk(got_status == 1'b1 && got_data == 64'd0, "R5 read out of range",
          got_data, 64'd0);
   endtask

   task automatic t_fill;
      run_cmd(2'd2, 64'h10, 64'h1000, 64'h55, 64'd0);
      expect_resp("R6 zero count", 1'b1, 0);
      run_cmd(2'd2, 64'h10, 64'h1000, 64'h55, 64'd9);
      expect_resp("R6 count over table", 1'b1, 0);
      run_cmd(2'd2, 64'h10, 64'h1800, 64'h7700_0002, 64'd3);
      expect_resp("R6 fill", 1'b0, 3);
      chk(last_iova == 64'h3000 && last_perm == 2'd2, "R10 fill last notice",
          last_iova, 64'h3000);
      for (int i = 1; i <= 3; i++)
         expect_entry("R6", 64'h10, 64'(i) << 12, 64'h7700_0002);
      run_cmd(2'd2, 64'h20, 64'h1_000E_0000, 64'h9000_0003, 64'd4);
      expect_resp("R9 fill overrun", 1'b1, 2);
      expect_entry("R9 kept", 64'h20, 64'h1_000E_0000, 64'h9000_0003);
      expect_entry("R9 kept", 64'h20, 64'h1_000F_0000, 64'h9000_0003);
   endtask

   task automatic t_list;
      run_cmd(2'd3, 64'h20, 64'h1_0004_0000, 64'h4000, 64'd513);
      expect_resp("R7 count over 512", 1'b1, 0);
      run_cmd(2'd3, 64'h20, 64'h1_0004_0000, 64'h4008, 64'd2);
      expect_resp("R7 misaligned list", 1'b1, 0);
      run_cmd(2'd3, 64'h20, 64'h1_0004_0000, 64'h4000, 64'd0);
      expect_resp("R7 zero count", 1'b1, 0);
      listmem[0] = 64'h0102_0304_0506_0701;
      listmem[1] = 64'h1112_1314_1516_1712;
      listmem[2] = 64'h2122_2324_2526_2723;
      run_cmd(2'd3, 64'h20, 64'h1_0004_0000, 64'h4000, 64'd3);
      expect_resp("R8 list write", 1'b0, 3);
      chk(last_iova == 64'h1_0006_0000, "R8 last page", last_iova, 64'h1_0006_0000);
      chk(last_xlat == 64'h2122_2324_2526_0000, "R10 list xlat", last_xlat,
          64'h2122_2324_2526_0000);
      for (int i = 0; i < 3; i++)
         expect_entry("R8", 64'h20, 64'h1_0004_0000 + (64'(i) << 16), listmem[i]);
      listmem[0] = 64'hAA00_0000_0000_1003;
      listmem[1] = 64'hBB00_0000_0000_2001;
      run_cmd(2'd3, 64'h10, 64'h6000, 64'h0, 64'd512);
      expect_resp("R9 list overrun", 1'b1, 2);
      expect_entry("R9 list kept", 64'h10, 64'h6000, 64'hAA00_0000_0000_1003);
      expect_entry("R9 list kept", 64'h10, 64'h7000, 64'hBB00_0000_0000_2001);
   endtask

   task automatic t_busy_ignore;
      int resps;
      @(negedge clk);
      cmd_op = 2'd2; cmd_id = 64'h20; cmd_addr = 64'h1_0008_0000;
      cmd_data = 64'h33; cmd_count = 64'd3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy, "R11 busy after accept", {63'd0, busy}, 64'd1);
      @(negedge clk);
      cmd_op = 2'd0; cmd_id = 64'h10; cmd_addr = 64'h0; cmd_data = 64'hDEAD_0003;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      resps = 0;
      for (int i = 0; i < 20; i++) begin
         if (resp_valid) resps++;
         @(negedge clk);
      end
      chk(resps == 1, "R11 single response", 64'(resps), 64'd1);
      expect_entry("R11 ignored command", 64'h10, 64'h0, 64'd0);
      expect_entry("R6 busy fill", 64'h20, 64'h1_000A_0000, 64'h33);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) listmem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_store_read;
      t_bad_id;
      t_bounds;
      t_fill;
      t_list;
      t_busy_ignore;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule